// File: doc/BRIEF.md
# Audio Serial Receiver with Half-Word Status Flags

This block is the receive side of a three-wire serial audio link in which an external master owns the bit clock and the word-select line. It samples serial data on the rising edge of the bit clock and splits every audio slot into 16-bit half-words. Each half-word is sent across to the host clock domain and placed in a single-entry receive buffer, tagged with the word-select side it arrived on. Framing follows the Philips convention: the first bit of a slot, which is its most significant bit, sits one bit clock after the word-select change.

The host sees three words, chosen by a two-bit address. Address 0 is control. Address 1 is status, and writes to it are ignored. Address 2 is the received half-word, and reading it pops the buffer. A received half-word raises a level interrupt, and so does an overrun, each behind its own enable bit.

When the enable bit is cleared, the half-word already being shifted is still finished. The receiver stops only after that.

Top module: `i2srx_receiver`

## Requirements
- R1: With the wide-slot control bit (control bit 3) at 0, each 16-bit slot gives exactly one half-word. The bit sampled on the first rising bit-clock edge after the edge that saw word-select change is the half-word's bit 15. The following bits run down to bit 0.
- R2: With control bit 3 at 1, each 32-bit slot gives two half-words: bits 31..16 first, then bits 15..0.
- R3: When a half-word lands in an empty buffer, status bit 0 (not-empty) sets. irq_rx is high whenever status bit 0 is 1 and control bit 1 (receive interrupt enable) is 1.
- R4: A read at address 2 returns the buffered half-word and clears status bit 0.
- R5: If a half-word completes while status bit 0 is still 1, status bit 1 (overrun) sets and the buffered half-word is kept. irq_err is high whenever status bit 1 is 1 and control bit 2 (error interrupt enable) is 1.
- R6: The overrun flag clears only after a read of address 2 followed by a read of address 1. A data read on its own leaves it set.
- R7: Status bit 3 gives the word-select level (0 = left, 1 = right) of the slot that the buffered half-word came from.
- R8: Status bit 2 (busy) reads 1 while the receiver is enabled and a half-word is partly shifted in. It reads 0 whenever control bit 0 (enable) is 0. Writes to address 1 change no status bit.
- R9: If control bit 0 is cleared partway through a half-word, that half-word is still delivered. No later half-word is delivered.
- R10: After reset, control, status and data all read 0, and both interrupts are low.
- R11: At a bit-clock period of four host clocks, every half-word of a frame reaches the host in order, with none lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| host_addr | input | 2 | Word select: 0 control, 1 status, 2 data |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe; gives the side effects of reading the data or status word |
| host_wdata | input | 4 | Control write value: bit 0 enable, bit 1 receive interrupt enable, bit 2 error interrupt enable, bit 3 wide slot |
| host_rdata | output | 16 | Read value of the addressed word (combinational) |
| irq_rx | output | 1 | Receive interrupt |
| irq_err | output | 1 | Overrun interrupt |
| i2s_sck | input | 1 | Bit clock from the external master |
| i2s_ws | input | 1 | Word select from the external master |
| i2s_sd | input | 1 | Serial data |

## Verification
The assertions assume that the host never reads the data word in the same host cycle in which a new half-word is handed over. They also assume that a handed-over half-word stays stable for several host cycles, which holds because the bit clock runs well below the host clock. The stimulus keeps to this in two ways. Word-select toggles cleanly on falling bit-clock edges at a fixed four-to-one clock ratio. The host polls status without side effects and reads each half-word long before the next one completes. Between frames, word-select keeps toggling in short idle slots, so no stray half-word ever completes.

// File: rtl/i2srx_pkg.sv
package i2srx_pkg;
   typedef enum logic [1:0] {
      ADDR_CTRL = 2'd0,
      ADDR_STAT = 2'd1,
      ADDR_DATA = 2'd2
   } addr_e;

   localparam int CTRL_W  = 4;
   localparam int STAT_W  = 4;
   localparam int ST_RXNE = 0;
   localparam int ST_OVR  = 1;
   localparam int ST_BUSY = 2;
   localparam int ST_SIDE = 3;

   typedef struct packed {
      logic wide;
      logic err_ie;
      logic rx_ie;
      logic en;
   } ctrl_t;
endpackage

// File: rtl/i2srx_sync.sv
module i2srx_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2srx_deser.sv
module i2srx_deser #(
   parameter int DATA_W = 16
) (
   input  logic              sck,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wide,
   input  logic              ws,
   input  logic              sd,
   output logic [DATA_W-1:0] pkt_data,
   output logic              pkt_side,
   output logic              pkt_tgl,
   output logic              busy
);
   localparam int LOW_W = $clog2(DATA_W);
   localparam int POS_W = LOW_W + 1;

   logic [POS_W-1:0]  pos;
   logic [DATA_W-2:0] sr;
   logic              ws_prev;
   logic              running;
   logic              side_cur;
   logic              ws_edge;
   logic              last_bit;
   logic              complete;

   assign ws_edge  = ws ^ ws_prev;
   assign last_bit = (&pos[LOW_W-1:0]) && (wide || !pos[LOW_W]);
   assign complete = running && last_bit;

   always_ff @(posedge sck or negedge rst_n) begin
      if (!rst_n) begin
         ws_prev  <= 1'b0;
         running  <= 1'b0;
         side_cur <= 1'b0;
         pos      <= '0;
         sr       <= '0;
         pkt_data <= '0;
         pkt_side <= 1'b0;
         pkt_tgl  <= 1'b0;
         busy     <= 1'b0;
      end else begin
         ws_prev <= ws;
         if (ws_edge) begin
            pos      <= '0;
            side_cur <= ws;
         end else if (running) begin
            pos <= pos + POS_W'(1);
         end
         if (running) begin
            sr <= {sr[DATA_W-3:0], sd};
            if (complete) begin
               pkt_data <= {sr, sd};
               pkt_side <= side_cur;
               pkt_tgl  <= ~pkt_tgl;
            end
         end
         if (!running)             running <= ws_edge && en;
         else if (complete && !en) running <= 1'b0;
         busy <= running && !complete;
      end
   end
endmodule

// File: rtl/i2srx_hostregs.sv
module i2srx_hostregs
   import i2srx_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [CTRL_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              irq_rx,
   output logic              irq_err,
   input  logic              pkt_event,
   input  logic [DATA_W-1:0] pkt_data,
   input  logic              pkt_side,
   input  logic              busy_s,
   output logic              cfg_en,
   output logic              cfg_wide,
   output logic [STAT_W-1:0] stat_vec,
   output logic [DATA_W-1:0] rx_word
);
   ctrl_t ctrl;
   logic  rxne, ovr, ovr_armed, side_q;
   logic  data_rd, stat_rd, rxne_keep;

   assign data_rd   = host_rd && (host_addr == ADDR_DATA);
   assign stat_rd   = host_rd && (host_addr == ADDR_STAT);
   assign rxne_keep = rxne && !data_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl      <= '0;
         rxne      <= 1'b0;
         ovr       <= 1'b0;
         ovr_armed <= 1'b0;
         side_q    <= 1'b0;
         rx_word   <= '0;
      end else begin
         if (host_wr && (host_addr == ADDR_CTRL)) ctrl <= host_wdata;
         rxne <= pkt_event || rxne_keep;
         if (pkt_event && !rxne_keep) begin
            rx_word <= pkt_data;
            side_q  <= pkt_side;
         end
         if (pkt_event && rxne_keep) begin
            ovr       <= 1'b1;
            ovr_armed <= 1'b0;
         end else if (data_rd && ovr) begin
            ovr_armed <= 1'b1;
         end else if (stat_rd && ovr_armed) begin
            ovr       <= 1'b0;
            ovr_armed <= 1'b0;
         end
      end
   end

   always_comb begin
      stat_vec          = '0;
      stat_vec[ST_RXNE] = rxne;
      stat_vec[ST_OVR]  = ovr;
      stat_vec[ST_BUSY] = ctrl.en && busy_s;
      stat_vec[ST_SIDE] = side_q;
   end

   always_comb begin
      case (host_addr)
         ADDR_CTRL: host_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
         ADDR_STAT: host_rdata = {{(DATA_W-STAT_W){1'b0}}, stat_vec};
         ADDR_DATA: host_rdata = rx_word;
         default:   host_rdata = '0;
      endcase
   end

   assign irq_rx   = rxne && ctrl.rx_ie;
   assign irq_err  = ovr && ctrl.err_ie;
   assign cfg_en   = ctrl.en;
   assign cfg_wide = ctrl.wide;
endmodule

// File: rtl/i2srx_receiver.sv
module i2srx_receiver
   import i2srx_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [CTRL_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              irq_rx,
   output logic              irq_err,
   input  logic              i2s_sck,
   input  logic              i2s_ws,
   input  logic              i2s_sd
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if ((1 << $clog2(DATA_W)) != DATA_W || DATA_W < 8) begin : g_bad_width
         $error("DATA_W must be a power of two of at least 8");
      end
   endgenerate

   logic              cfg_en, cfg_wide;
   logic              en_b, wide_b;
   logic [DATA_W-1:0] pkt_data;
   logic              pkt_side, pkt_tgl, busy_b;
   logic              tgl_s, busy_s, tgl_prev;
   logic              pkt_event;
   logic [STAT_W-1:0] stat_vec;
   logic [DATA_W-1:0] rx_word;

   i2srx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_to_bitclk (
      .clk(i2s_sck), .rst_n(rst_n), .d({cfg_wide, cfg_en}), .q({wide_b, en_b})
   );

   i2srx_deser #(.DATA_W(DATA_W)) u_deser (
      .sck(i2s_sck), .rst_n(rst_n), .en(en_b), .wide(wide_b),
      .ws(i2s_ws), .sd(i2s_sd), .pkt_data(pkt_data), .pkt_side(pkt_side),
      .pkt_tgl(pkt_tgl), .busy(busy_b)
   );

   i2srx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_to_host (
      .clk(clk), .rst_n(rst_n), .d({busy_b, pkt_tgl}), .q({busy_s, tgl_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tgl_prev <= 1'b0;
      else        tgl_prev <= tgl_s;
   end
   assign pkt_event = tgl_s ^ tgl_prev;

   i2srx_hostregs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .irq_rx(irq_rx), .irq_err(irq_err), .pkt_event(pkt_event),
      .pkt_data(pkt_data), .pkt_side(pkt_side), .busy_s(busy_s),
      .cfg_en(cfg_en), .cfg_wide(cfg_wide), .stat_vec(stat_vec), .rx_word(rx_word)
   );
endmodule

// File: rtl/i2srx_receiver_chk.sv
module i2srx_receiver_chk
   import i2srx_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        host_addr,
   input logic              host_rd,
   input logic              cfg_en,
   input logic              pkt_event,
   input logic [STAT_W-1:0] stat_vec,
   input logic [DATA_W-1:0] rx_word,
   input logic              irq_err
);
   logic data_rd;
   assign data_rd = host_rd && (host_addr == ADDR_DATA);

   AST_RXNE_ON_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_event |=> stat_vec[ST_RXNE]); // R3
   AST_RXNE_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !pkt_event) |=> !stat_vec[ST_RXNE]); // R4
   AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_event && stat_vec[ST_RXNE] && !data_rd) |=> stat_vec[ST_OVR]); // R5
   AST_OVR_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_event && stat_vec[ST_RXNE] && !data_rd) |=> $stable(rx_word)); // R5
   AST_IRQ_ERR_NEEDS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
      irq_err |-> stat_vec[ST_OVR]); // R5
   AST_BUSY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |-> !stat_vec[ST_BUSY]); // R8
endmodule

bind i2srx_receiver i2srx_receiver_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
   .cfg_en(cfg_en), .pkt_event(pkt_event), .stat_vec(stat_vec),
   .rx_word(rx_word), .irq_err(irq_err)
);

// File: tb/i2srx_receiver_test.sv
module i2srx_receiver_test;
   localparam int CLK_PERIOD = 10;
   localparam int SCK_PERIOD = 4 * CLK_PERIOD;
   localparam int NVEC = 5;
   // {wide, left slot value, right slot value}
   localparam logic [64:0] VECTORS [NVEC] = '{
      {1'b0, 32'h0000_A5C3, 32'h0000_3C5A},
      {1'b0, 32'h0000_FFFF, 32'h0000_0001},
      {1'b1, 32'h1234_5678, 32'h9ABC_DEF0},
      {1'b1, 32'h8000_0001, 32'h7FFF_FFFE},
      {1'b0, 32'h0000_8000, 32'h0000_0000}
   };

   logic        clk = 0, sck = 0, rst_n = 0;
   logic [1:0]  host_addr = 0;
   logic        host_wr = 0, host_rd = 0;
   logic [3:0]  host_wdata = 0;
   logic [15:0] host_rdata;
   logic        irq_rx, irq_err;
   logic        ws = 0, sd = 0;

   int errors = 0, checks = 0;
   bit done = 0;

   bit sdv [0:79];
   bit sidev [0:79];
   int q_len = 0, q_idx = 0, idle_cnt = 0;
   bit q_req = 0, q_ack = 0, stream_on = 0;

   i2srx_receiver uut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .irq_rx(irq_rx), .irq_err(irq_err), .i2s_sck(sck), .i2s_ws(ws), .i2s_sd(sd)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always #(SCK_PERIOD/2) sck = ~sck;

   // serial driver: stream bits when requested, otherwise short idle slots
   always @(negedge sck) begin
      if (q_req != q_ack) begin
         q_ack = q_req; q_idx = 0; stream_on = 1;
      end
      if (stream_on) begin
         sd = sdv[q_idx];
         ws = sidev[q_idx+1];
         q_idx++;
         if (q_idx == q_len) begin stream_on = 0; idle_cnt = 0; end
      end else begin
         sd = 0;
         if (idle_cnt == 7) begin ws = ~ws; idle_cnt = 0; end
         else idle_cnt++;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic write_reg(input logic [1:0] a, input logic [3:0] v);
      @(negedge clk); host_addr = a; host_wdata = v; host_wr = 1;
      @(negedge clk); host_wr = 0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [15:0] v);
      @(negedge clk); host_addr = a; host_rd = 0; #1 v = host_rdata;
   endtask

   task automatic read_reg(input logic [1:0] a, output logic [15:0] v);
      @(negedge clk); host_addr = a; host_rd = 1; #1 v = host_rdata;
      @(negedge clk); host_rd = 0;
   endtask

   task automatic play(input bit wide, input logic [31:0] l, input logic [31:0] r);
      int n = 0;
      int w = wide ? 32 : 16;
      for (int i = 0; i < 4; i++) begin sdv[n] = 0; sidev[n] = 1; n++; end
      for (int i = w-1; i >= 0; i--) begin sdv[n] = l[i]; sidev[n] = 0; n++; end
      for (int i = w-1; i >= 0; i--) begin sdv[n] = r[i]; sidev[n] = 1; n++; end
      for (int i = 0; i < 3; i++) begin sdv[n] = 0; sidev[n] = 0; n++; end
      q_len = n - 1;
      q_req = ~q_req;
      wait (q_ack == q_req);
      wait (stream_on == 0);
   endtask

   task automatic wait_rxne(input string req);
      logic [15:0] v;
      int t = 0;
      do begin peek(2'd1, v); t++; end while (!v[0] && t < 600);
      if (!v[0]) check(req, 32'(v[0]), 32'h1);
   endtask

   initial begin
      #(CLK_PERIOD * 120000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL R11 watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] v, st;
      repeat (5) @(negedge clk);
      rst_n = 1;
      repeat (3) @(negedge clk);

      // R10 reset state
      peek(2'd0, v); check("R10 ctrl", 32'(v), 0);
      peek(2'd1, v); check("R10 status", 32'(v), 0);
      peek(2'd2, v); check("R10 data", 32'(v), 0);
      check("R10 irqs", {30'd0, irq_rx, irq_err}, 0);

      // table walk: R1 R2 R7 R11
      for (int i = 0; i < NVEC; i++) begin
         logic        wide = VECTORS[i][64];
         logic [31:0] lv = VECTORS[i][63:32];
         logic [31:0] rv = VECTORS[i][31:0];
         int np = wide ? 4 : 2;
         write_reg(2'd0, {wide, 3'b001});
         fork play(wide, lv, rv); join_none
         for (int k = 0; k < np; k++) begin
            logic [15:0] ew;
            logic        es;
            if (wide) begin
               case (k)
                  0: ew = lv[31:16];
                  1: ew = lv[15:0];
                  2: ew = rv[31:16];
                  default: ew = rv[15:0];
               endcase
               es = (k >= 2);
            end else begin
               ew = (k == 0) ? lv[15:0] : rv[15:0];
               es = (k == 1);
            end
            wait_rxne("R11 packet arrival");
            peek(2'd1, st);
            check("R7 side", 32'(st[3]), 32'(es));
            read_reg(2'd2, v);
            check(wide ? "R2 wide half-word" : "R1 narrow half-word", 32'(v), 32'(ew));
         end
         wait fork;
         peek(2'd1, st);
         check("R11 no extra packet", 32'(st[1:0]), 0);
      end

      // R3 R4 receive interrupt and read clear
      write_reg(2'd0, 4'b0011);
      fork play(1'b0, 32'h0000_1357, 32'h0000_2468); join_none
      wait_rxne("R3 packet");
      check("R3 irq_rx set", 32'(irq_rx), 1);
      read_reg(2'd2, v);
      check("R4 data value", 32'(v), 32'h1357);
      peek(2'd1, st);
      check("R4 rxne cleared", 32'(st[0]), 0);
      check("R3 irq_rx cleared", 32'(irq_rx), 0);
      wait_rxne("R3 second packet");
      read_reg(2'd2, v);
      check("R4 second data", 32'(v), 32'h2468);
      wait fork;

      // R8 busy and ignored status write, then R5 R6 overrun
      write_reg(2'd0, 4'b0101);
      fork play(1'b0, 32'h0000_CAFE, 32'h0000_BEEF); join_none
      repeat (10) @(negedge sck);
      peek(2'd1, st);
      check("R8 busy mid half-word", 32'(st[2]), 1);
      write_reg(2'd1, 4'hF);
      peek(2'd1, st);
      check("R8 status write ignored", 32'(st[1:0]), 0);
      wait fork;
      peek(2'd1, st);
      check("R5 overrun flags", 32'({st[3], st[1:0]}), 32'b011);
      check("R5 irq_err", 32'(irq_err), 1);
      read_reg(2'd2, v);
      check("R5 kept word", 32'(v), 32'hCAFE);
      peek(2'd1, st);
      check("R6 ovr after data read", 32'(st[1]), 1);
      read_reg(2'd1, st);
      peek(2'd1, st);
      check("R6 ovr after status read", 32'(st[1]), 0);
      check("R6 irq_err cleared", 32'(irq_err), 0);

      // R9 disable partway through the left half-word
      write_reg(2'd0, 4'b0001);
      fork play(1'b0, 32'h0000_0F0F, 32'h0000_F0F0); join_none
      repeat (9) @(negedge sck);
      write_reg(2'd0, 4'b0000);
      wait fork;
      repeat (40) @(negedge sck);
      peek(2'd1, st);
      check("R9 one packet, no overrun", 32'(st), 32'h1);
      read_reg(2'd2, v);
      check("R9 finished half-word", 32'(v), 32'h0F0F);
      repeat (40) @(negedge sck);
      peek(2'd1, st);
      check("R9 nothing after stop", 32'(st), 0);
      check("R8 busy masked when disabled", 32'(st[2]), 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule